// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation cache. Every slot holds a virtual page number, a physical frame number, three protection bits (read, write, execute), a valid flag and an 8-bit address-space tag. A combinational lookup port compares the requested page number against every slot and reports a hit, the frame and the protection bits. Only slots whose tag equals the current address-space register take part, so translations belonging to several processes can sit in the buffer at once.

The current address-space register is loaded by a privileged write at each context switch. An install port stores a new translation under the current tag. It reuses the slot that already holds the same page and tag, else the lowest-numbered empty slot, else a victim picked by a round-robin pointer. A flush input invalidates all slots in one cycle. A write to the page-table base register also flushes, but only while the mode input says tagging is off.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses (`lk_hit`=0), and the current address-space register holds 0.
- R2: A lookup hits only on a valid slot whose page number equals `lk_vpn` and whose tag equals the current address-space register. It reports in the same cycle as the request.
- R3: One page number may be valid under two different tags with different frames. The lookup returns the frame installed under the current tag.
- R4: A write on `asid_we` loads `asid_wdata` at the next clock edge. Lookups from that edge onward use the new tag.
- R5: Different page numbers under different tags may map to the same frame. Each one hits with its own protection bits.
- R6: Installing a page number that is already valid under the current tag overwrites that slot's frame and protection. No second copy is made, and the victim pointer does not move.
- R7: With no matching slot, an install fills the lowest-numbered invalid slot. If none is invalid, it evicts the slot at the round-robin pointer.
- R8: The round-robin pointer starts at slot 0 after reset and advances by one (wrapping) on each eviction only.
- R9: `flush` high at a clock edge invalidates every slot. A page-table base write (`ptb_we`) does the same while `tag_mode`=0.
- R10: While `tag_mode`=1, a page-table base write leaves every slot unchanged.
- R11: A flush takes priority over an install in the same cycle: the install is dropped and the buffer is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup hit under current tag |
| lk_pfn | output | PFN_W | Frame number of hitting slot (0 on miss) |
| lk_perm | output | 3 | Protection bits {r,w,x} of hitting slot (0 on miss) |
| ins_en | input | 1 | Install a translation under the current tag |
| ins_vpn | input | VPN_W | Page number to install |
| ins_pfn | input | PFN_W | Frame number to install |
| ins_perm | input | 3 | Protection bits {r,w,x} to install |
| asid_we | input | 1 | Privileged write of current address-space register |
| asid_wdata | input | ASID_W | New address-space tag |
| flush | input | 1 | Invalidate all slots |
| ptb_we | input | 1 | Page-table base register written |
| tag_mode | input | 1 | 1: tagging active, base writes ignored; 0: base writes flush |

## Verification
A corrupted valid flag or tag shows up as a wrong hit or a wrong miss on the first lookup of that page under the affected tag. Because the lookup path is combinational, this happens in the same cycle the page is requested. A victim pointer that drifts stays hidden until the buffer is full. It then shows one install later, when the wrong page goes missing while its neighbour survives, so the bench fills the buffer and probes both the evicted and the surviving pages after each eviction. Flush and base-write faults show on the very next lookup after the edge.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_perm,
  input  logic              ins_en,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic [2:0]        ins_perm,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  input  logic              flush,
  input  logic              ptb_we,
  input  logic              tag_mode
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [ASID_W-1:0]  tag_q  [ENTRIES];
  logic [ASID_W-1:0]  cur_asid;
  logic [IW-1:0]      rr_ptr;

  logic [ENTRIES-1:0] hit_vec, same_vec;
  logic [IW-1:0]      same_idx, free_idx, slot;
  logic               do_clr, do_ins, evict;

  assign do_clr = flush | (ptb_we & ~tag_mode);
  assign do_ins = ins_en & ~do_clr;

  always_comb begin
    lk_pfn   = '0;
    lk_perm  = '0;
    same_idx = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i]  = valid[i] && vpn_q[i] == lk_vpn  && tag_q[i] == cur_asid;
      same_vec[i] = valid[i] && vpn_q[i] == ins_vpn && tag_q[i] == cur_asid;
      if (hit_vec[i]) begin
        lk_pfn  = lk_pfn  | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
      if (same_vec[i]) same_idx = IW'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IW'(i);
  end

  assign lk_hit = |hit_vec;
  assign evict  = do_ins & ~|same_vec & &valid;
  assign slot   = |same_vec ? same_idx : (&valid ? rr_ptr : free_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= '0;
      cur_asid <= '0;
      rr_ptr   <= '0;
    end else begin
      if (asid_we) cur_asid <= asid_wdata;
      if (do_clr) valid <= '0;
      else if (do_ins) valid[slot] <= 1'b1;
      if (evict) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      vpn_q[slot]  <= ins_vpn;
      pfn_q[slot]  <= ins_pfn;
      perm_q[slot] <= ins_perm;
      tag_q[slot]  <= cur_asid;
    end
  end

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R4
  asid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asid_we |=> cur_asid == $past(asid_wdata));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid == '0);
  // R9
  ptb_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_we && !tag_mode) |=> !lk_hit || $changed(lk_vpn) || valid == '0);
  // R10
  ptb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_we && tag_mode && !flush && !ins_en) |=> $stable(valid));
  // R8
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1));
  // R8
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evict |=> $stable(rr_ptr));
  // R11
  clr_beats_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && ins_en) |=> valid == '0);
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int VW = 20, PW = 20, AW = 8;
  logic clk = 0, rst_n = 0;
  logic [VW-1:0] lk_vpn = '0, ins_vpn = '0;
  logic [PW-1:0] ins_pfn = '0, lk_pfn;
  logic [2:0] ins_perm = '0, lk_perm;
  logic lk_hit, ins_en = 0, asid_we = 0, flush = 0, ptb_we = 0, tag_mode = 1;
  logic [AW-1:0] asid_wdata = '0;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  asid_tlb #(.ENTRIES(4), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .lk_perm(lk_perm), .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn),
    .ins_perm(ins_perm), .asid_we(asid_we), .asid_wdata(asid_wdata),
    .flush(flush), .ptb_we(ptb_we), .tag_mode(tag_mode));

  typedef struct packed {
    logic [2:0]  op;
    logic [19:0] a;
    logic [19:0] b;
    logic [2:0]  perm;
    logic        ehit;
    logic [19:0] epfn;
    logic [2:0]  eperm;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [2:0] L = 0, A = 1, I = 2, F = 3, P = 4;
  localparam int N = 34;
  localparam vec_t TAB [N] = '{
    '{A, 20'd1,  0, 0, 0, 0, 0, 8'd4},
    '{I, 20'd10, 20'd100, 3'd7, 0, 0, 0, 8'd7},
    '{A, 20'd2,  0, 0, 0, 0, 0, 8'd4},
    '{I, 20'd10, 20'd170, 3'd7, 0, 0, 0, 8'd7},
    '{L, 20'd10, 0, 0, 1, 20'd170, 3'd7, 8'd3},   // R3
    '{A, 20'd1,  0, 0, 0, 0, 0, 8'd4},
    '{L, 20'd10, 0, 0, 1, 20'd100, 3'd7, 8'd4},   // R4
    '{I, 20'd20, 20'd101, 3'd5, 0, 0, 0, 8'd7},
    '{A, 20'd2,  0, 0, 0, 0, 0, 8'd4},
    '{I, 20'd50, 20'd101, 3'd5, 0, 0, 0, 8'd7},
    '{L, 20'd50, 0, 0, 1, 20'd101, 3'd5, 8'd5},   // R5
    '{L, 20'd20, 0, 0, 0, 0, 0, 8'd2},            // R2 other tag
    '{A, 20'd1,  0, 0, 0, 0, 0, 8'd4},
    '{L, 20'd20, 0, 0, 1, 20'd101, 3'd5, 8'd5},   // R5
    '{I, 20'd60, 20'd200, 3'd6, 0, 0, 0, 8'd7},   // full: evict slot 0
    '{L, 20'd10, 0, 0, 0, 0, 0, 8'd7},            // R7
    '{L, 20'd60, 0, 0, 1, 20'd200, 3'd6, 8'd7},   // R7
    '{I, 20'd70, 20'd300, 3'd1, 0, 0, 0, 8'd8},   // evict slot 1
    '{A, 20'd2,  0, 0, 0, 0, 0, 8'd4},
    '{L, 20'd10, 0, 0, 0, 0, 0, 8'd8},            // R8
    '{A, 20'd1,  0, 0, 0, 0, 0, 8'd4},
    '{I, 20'd60, 20'd222, 3'd3, 0, 0, 0, 8'd6},   // overwrite
    '{L, 20'd60, 0, 0, 1, 20'd222, 3'd3, 8'd6},   // R6
    '{I, 20'd80, 20'd400, 3'd2, 0, 0, 0, 8'd8},   // evict slot 2
    '{L, 20'd20, 0, 0, 0, 0, 0, 8'd8},            // R8
    '{L, 20'd80, 0, 0, 1, 20'd400, 3'd2, 8'd6},   // R6 pointer held
    '{A, 20'd2,  0, 0, 0, 0, 0, 8'd4},
    '{L, 20'd50, 0, 0, 1, 20'd101, 3'd5, 8'd8},   // R8 slot 3 kept
    '{A, 20'd1,  0, 0, 0, 0, 0, 8'd4},
    '{P, 20'd1,  0, 0, 0, 0, 0, 8'd10},
    '{L, 20'd80, 0, 0, 1, 20'd400, 3'd2, 8'd10},  // R10
    '{P, 20'd0,  0, 0, 0, 0, 0, 8'd9},
    '{L, 20'd80, 0, 0, 0, 0, 0, 8'd9},            // R9
    '{L, 20'd70, 0, 0, 0, 0, 0, 8'd9}             // R9
  };

  task automatic look(input logic [19:0] v, input logic eh, input logic [19:0] ep,
                      input logic [2:0] er, input int rq);
    @(negedge clk);
    lk_vpn = v;
    #2;
    checks++;
    if (lk_hit !== eh || lk_pfn !== ep || lk_perm !== er) begin
      fails++;
      $display("FAIL R%0d vpn=%0d got hit=%0b pfn=%0d perm=%0d exp hit=%0b pfn=%0d perm=%0d",
               rq, v, lk_hit, lk_pfn, lk_perm, eh, ep, er);
    end
  endtask

  task automatic step(input vec_t t);
    @(negedge clk);
    case (t.op)
      A: begin asid_we = 1; asid_wdata = t.a[7:0]; end
      I: begin ins_en = 1; ins_vpn = t.a; ins_pfn = t.b; ins_perm = t.perm; end
      F: flush = 1;
      P: begin ptb_we = 1; tag_mode = t.a[0]; end
      default: ;
    endcase
    @(posedge clk);
    #2;
    asid_we = 0; ins_en = 0; flush = 0; ptb_we = 0; tag_mode = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(20'd0, 0, 0, 0, 1);     // R1
    look(20'd10, 0, 0, 0, 1);    // R1
    for (int k = 0; k < N; k++) begin
      if (TAB[k].op == L) look(TAB[k].a, TAB[k].ehit, TAB[k].epfn, TAB[k].eperm, int'(TAB[k].rq));
      else step(TAB[k]);
    end
    // R11: flush and install together
    @(negedge clk);
    flush = 1; ins_en = 1; ins_vpn = 20'd90; ins_pfn = 20'd900; ins_perm = 3'd4;
    @(posedge clk); #2; flush = 0; ins_en = 0;
    look(20'd90, 0, 0, 0, 11);
    // R2 / R9: install then plain flush
    step('{I, 20'd91, 20'd910, 3'd4, 0, 0, 0, 8'd2});
    look(20'd91, 1, 20'd910, 3'd4, 2);
    step('{F, 20'd0, 0, 0, 0, 0, 0, 8'd9});
    look(20'd91, 0, 0, 0, 9);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule